// File: doc/BRIEF.md
# Two-Strobe Transmit Word Queue

This block buffers outgoing 31-bit words for a serial transmitter. A host with a 16-bit bus writes each word in two steps. A first load strobe latches the lower half. A second load strobe supplies the upper half and commits the joined word to the next free slot. The queue holds up to eight words. The serializer takes words from it in arrival order by raising a pop request, and the queue returns the oldest word one cycle later.

An occupancy count is kept beside the storage. The ready flag is driven from that count, so it reads high only when every committed word has been handed to the serializer. Space being free is not enough to raise it. Loads that arrive while all eight slots are taken are dropped silently. A second-half strobe with no first half pending is also dropped.

Top module: `txWordFifo`

## Requirements
- R1: After reset, wordCount is 0, allSent is 1 and popValid is 0.
- R2: A loadLow cycle latches busData[15:0] as word bits [15:0]. A committing loadHigh cycle supplies busData[14:0] as word bits [30:16]. busData[15] on the loadHigh cycle has no effect on the stored word.
- R3: loadLow alone never changes wordCount. A loadHigh with a half pending and the queue not full raises wordCount by one at that clock edge.
- R4: A loadHigh with no loadLow since the last loadHigh is ignored: wordCount and the stored words are unchanged.
- R5: Words leave in the order they were committed, and at most 8 are held.
- R6: A loadHigh while 8 words are held is dropped. wordCount stays 8 and the held words are unchanged. The pending lower half is discarded, so a later loadHigh alone commits nothing.
- R7: A popReq cycle with wordCount above 0 gives popValid=1 and the oldest word on popWord in the next cycle, and decrements wordCount.
- R8: A popReq cycle with wordCount 0 gives no popValid and leaves the queue unchanged.
- R9: allSent is 1 exactly when wordCount is 0. It falls right after the committing loadHigh edge and rises after the edge that pops the last word.
- R10: A commit and a pop in the same cycle both take effect. When the queue was empty, that pop returns nothing and the word is kept.
- R11: When loadLow and loadHigh are high in the same cycle, the commit uses the previously latched lower half. The new lower half stays pending for the next loadHigh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busData | input | 16 | Host data bus half-word |
| loadLow | input | 1 | First-half load strobe, one cycle per load |
| loadHigh | input | 1 | Second-half load strobe, commits the word |
| popReq | input | 1 | Serializer request for the next word |
| popValid | output | 1 | popWord holds a popped word this cycle |
| popWord | output | 31 | Oldest word, registered |
| wordCount | output | 4 | Words currently held |
| allSent | output | 1 | High when no word remains to send |

## Verification
A second-half commit and a serializer pop can fall in the same clock cycle. So can both load strobes. The bench drives a pending lower half and then raises loadHigh together with popReq, once with one word already held and once with the queue empty. It judges the result by the unchanged or incremented wordCount and by whether a popped word appears the following cycle. For the overlapping strobes, it raises a new loadLow on the same cycle as loadHigh. The scoreboard then expects two words, each joined from the correct halves.

// File: rtl/txfifo_pkg.sv
package txfifo_pkg;
  // Per-cycle strobes from the control to the datapath
  typedef struct packed {
    logic capture;  // latch the lower half
    logic commit;   // write the joined word into the write slot
    logic pop;      // read the oldest slot into the output register
  } fifoStrobes_t;
endpackage

// File: rtl/txFifoCtrl.sv
module txFifoCtrl
  import txfifo_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             loadLow,
  input  logic             loadHigh,
  input  logic             popReq,
  output fifoStrobes_t     strobes,
  output logic [PTR_W-1:0] wrPtr,
  output logic [PTR_W-1:0] rdPtr,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

  logic lowValid;
  logic isFull;
  logic isEmpty;

  assign isFull  = (count == FULL_CNT);
  assign isEmpty = (count == '0);

  always_comb begin
    strobes.capture = loadLow;
    strobes.commit  = loadHigh && lowValid && !isFull;
    strobes.pop     = popReq && !isEmpty;
  end

  // Pending-half flag: a loadHigh consumes it, whether it commits or is dropped
  always_ff @(posedge clk) begin
    if (!rstN)         lowValid <= 1'b0;
    else if (loadLow)  lowValid <= 1'b1;
    else if (loadHigh) lowValid <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (strobes.commit) wrPtr <= (wrPtr == LAST_PTR) ? '0 : wrPtr + 1'b1;
      if (strobes.pop)    rdPtr <= (rdPtr == LAST_PTR) ? '0 : rdPtr + 1'b1;
      case ({strobes.commit, strobes.pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rstN)
    count <= FULL_CNT);

  assert_full_drop_R6: assert property (@(posedge clk) disable iff (!rstN)
    (isFull && loadHigh && !popReq) |=> (count == FULL_CNT) && $stable(wrPtr));

  assert_empty_pop_R8: assert property (@(posedge clk) disable iff (!rstN)
    (isEmpty && popReq && !(loadHigh && lowValid)) |=> (count == '0) && $stable(rdPtr));

  assert_lone_high_R4: assert property (@(posedge clk) disable iff (!rstN)
    (loadHigh && !lowValid && !popReq) |=> $stable(count) && $stable(wrPtr));

  assert_commit_step_R3: assert property (@(posedge clk) disable iff (!rstN)
    (loadHigh && lowValid && !isFull && !popReq) |=> count == CNT_W'($past(count) + 1'b1));

  assert_low_only_R3: assert property (@(posedge clk) disable iff (!rstN)
    (loadLow && !loadHigh && !popReq) |=> $stable(count));
endmodule

// File: rtl/txFifoData.sv
module txFifoData
  import txfifo_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int BUS_W  = 16,
  parameter int WORD_W = 31,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int HI_W  = WORD_W - BUS_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [BUS_W-1:0]  busData,
  input  fifoStrobes_t      strobes,
  input  logic [PTR_W-1:0]  wrPtr,
  input  logic [PTR_W-1:0]  rdPtr,
  output logic              popValid,
  output logic [WORD_W-1:0] popWord
);
  logic [BUS_W-1:0]  holdLow;
  logic [WORD_W-1:0] joined;
  logic [WORD_W-1:0] slots [DEPTH];
  logic [BUS_W-HI_W-1:0] unusedTop;

  assign joined    = {busData[HI_W-1:0], holdLow};
  assign unusedTop = busData[BUS_W-1:HI_W];

  always_ff @(posedge clk) begin
    if (!rstN)                holdLow <= '0;
    else if (strobes.capture) holdLow <= busData;
  end

  always_ff @(posedge clk) begin
    if (strobes.commit) slots[wrPtr] <= joined;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      popValid <= 1'b0;
      popWord  <= '0;
    end else begin
      popValid <= strobes.pop;
      if (strobes.pop) popWord <= slots[rdPtr];
    end
  end

  assert_pop_origin_R7: assert property (@(posedge clk) disable iff (!rstN)
    popValid |-> $past(strobes.pop));

  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.pop |=> !popValid && $stable(popWord));
endmodule

// File: rtl/txWordFifo.sv
module txWordFifo
  import txfifo_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int BUS_W  = 16,
  parameter int WORD_W = 31,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [BUS_W-1:0]  busData,
  input  logic              loadLow,
  input  logic              loadHigh,
  input  logic              popReq,
  output logic              popValid,
  output logic [WORD_W-1:0] popWord,
  output logic [CNT_W-1:0]  wordCount,
  output logic              allSent
);
  fifoStrobes_t     strobes;
  logic [PTR_W-1:0] wrPtr;
  logic [PTR_W-1:0] rdPtr;

  txFifoCtrl #(.DEPTH(DEPTH)) ctrl (
    .clk(clk), .rstN(rstN), .loadLow(loadLow), .loadHigh(loadHigh),
    .popReq(popReq), .strobes(strobes), .wrPtr(wrPtr), .rdPtr(rdPtr),
    .count(wordCount)
  );

  txFifoData #(.DEPTH(DEPTH), .BUS_W(BUS_W), .WORD_W(WORD_W)) data (
    .clk(clk), .rstN(rstN), .busData(busData), .strobes(strobes),
    .wrPtr(wrPtr), .rdPtr(rdPtr), .popValid(popValid), .popWord(popWord)
  );

  assign allSent = (wordCount == '0);

  assert_ready_rise_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(allSent) |-> $past(popReq));

  assert_ready_fall_R9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(allSent) |-> $past(loadHigh));
endmodule

// File: tb/txWordFifo_test.sv
module txWordFifo_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] busData = '0;
  logic        loadLow = 1'b0;
  logic        loadHigh = 1'b0;
  logic        popReq = 1'b0;
  logic        popValid;
  logic [30:0] popWord;
  logic [3:0]  wordCount;
  logic        allSent;

  int compared = 0;
  int mismatched = 0;
  int mCount = 0;
  int pendPops = 0;
  bit mLowValid = 1'b0;
  logic [15:0] mLow = '0;
  logic [30:0] expQ [$];

  always #5 clk = ~clk;

  txWordFifo uut (
    .clk(clk), .rstN(rstN), .busData(busData), .loadLow(loadLow),
    .loadHigh(loadHigh), .popReq(popReq), .popValid(popValid),
    .popWord(popWord), .wordCount(wordCount), .allSent(allSent)
  );

  task automatic check(input string tag, input int act, input int exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Monitor: every popped word is compared with the oldest expected word
  always @(negedge clk) begin
    if (rstN && popValid) begin
      compared++;
      if (pendPops == 0 || expQ.size() == 0) begin
        mismatched++;
        $display("FAIL R8: actual unexpected pop %h expected none", popWord);
      end else begin
        logic [30:0] want;
        want = expQ.pop_front();
        pendPops--;
        if (popWord !== want) begin
          mismatched++;
          $display("FAIL R7/R5: actual %h expected %h", popWord, want);
        end
      end
    end
  end

  // Driver: one clock of stimulus, expectations derived from the requirements
  task automatic stepCycle(input bit lo, input bit hi, input bit pop,
                           input logic [15:0] bus, input string tag);
    bit commit;
    bit popOk;
    commit = hi && mLowValid && (mCount < 8);
    popOk  = pop && (mCount > 0);
    loadLow = lo; loadHigh = hi; popReq = pop; busData = bus;
    @(negedge clk);
    loadLow = 1'b0; loadHigh = 1'b0; popReq = 1'b0;
    if (commit) expQ.push_back({bus[14:0], mLow});
    if (hi) mLowValid = 1'b0;
    if (lo) begin mLow = bus; mLowValid = 1'b1; end
    mCount = mCount + int'(commit) - int'(popOk);
    if (popOk) pendPops++;
    check({tag, " count"}, int'(wordCount), mCount);
    check({"R9 ", tag}, int'(allSent), int'(mCount == 0));
  endtask

  task automatic pushWord(input logic [30:0] w, input string tag);
    stepCycle(1'b1, 1'b0, 1'b0, w[15:0], tag);
    stepCycle(1'b0, 1'b1, 1'b0, {1'b1, w[30:16]}, tag);  // top bit unused (R2)
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 count", int'(wordCount), 0);
    check("R1 allSent", int'(allSent), 1);
    check("R1 popValid", int'(popValid), 0);

    stepCycle(1'b1, 1'b0, 1'b0, 16'hA5C3, "R3 low only");
    stepCycle(1'b0, 1'b1, 1'b0, 16'hFFFF, "R2 R3 commit");
    stepCycle(1'b0, 1'b1, 1'b0, 16'h1234, "R4 lone high");
    stepCycle(1'b0, 1'b0, 1'b1, 16'h0000, "R7 pop");
    stepCycle(1'b0, 1'b0, 1'b1, 16'h0000, "R8 empty pop");
    stepCycle(1'b0, 1'b0, 1'b0, 16'h0000, "R8 idle");

    // Fill to depth, then try one more
    for (int i = 0; i < 8; i++)
      pushWord(31'h1000_0000 + 31'(i * 31'h0013_5791), "R5 fill");
    pushWord(31'h7EAD_BEEF, "R6 full drop");
    for (int i = 0; i < 8; i++)
      stepCycle(1'b0, 1'b0, 1'b1, 16'h0000, "R5 drain");
    stepCycle(1'b0, 1'b0, 1'b0, 16'h0000, "R5 idle");

    // Commit and pop together: one word held, then empty
    pushWord(31'h0ABC_1111, "R10 setup");
    stepCycle(1'b1, 1'b0, 1'b0, 16'h2222, "R10 low");
    stepCycle(1'b0, 1'b1, 1'b1, 16'h3333, "R10 commit+pop");
    stepCycle(1'b0, 1'b0, 1'b1, 16'h0000, "R10 drain");
    stepCycle(1'b1, 1'b0, 1'b0, 16'h4444, "R10 low empty");
    stepCycle(1'b0, 1'b1, 1'b1, 16'h5555, "R10 commit+pop empty");
    stepCycle(1'b0, 1'b0, 1'b1, 16'h0000, "R10 drain2");
    stepCycle(1'b0, 1'b0, 1'b0, 16'h0000, "R10 idle");

    // Both strobes in one cycle
    stepCycle(1'b1, 1'b0, 1'b0, 16'hAAAA, "R11 first low");
    stepCycle(1'b1, 1'b1, 1'b0, 16'hBBBB, "R11 overlap");
    stepCycle(1'b0, 1'b1, 1'b0, 16'h0CCC, "R11 second high");
    stepCycle(1'b0, 1'b0, 1'b1, 16'h0000, "R11 pop1");
    stepCycle(1'b0, 1'b0, 1'b1, 16'h0000, "R11 pop2");
    stepCycle(1'b0, 1'b0, 1'b0, 16'h0000, "R11 idle");

    // Full drop discards the pending half
    for (int i = 0; i < 8; i++)
      pushWord(31'h2000_0000 + 31'(i * 31'h0101_0101), "R6 refill");
    stepCycle(1'b1, 1'b0, 1'b0, 16'h9999, "R6 pending low");
    stepCycle(1'b0, 1'b1, 1'b0, 16'h7777, "R6 dropped high");
    stepCycle(1'b0, 1'b0, 1'b1, 16'h0000, "R6 free slot");
    stepCycle(1'b0, 1'b1, 1'b0, 16'h6666, "R6 stale high");
    for (int i = 0; i < 7; i++)
      stepCycle(1'b0, 1'b0, 1'b1, 16'h0000, "R6 drain");
    stepCycle(1'b0, 1'b0, 1'b0, 16'h0000, "R6 idle");

    check("R5 leftover words", expQ.size(), 0);
    check("R7 pending pops", pendPops, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule